// File: doc/BRIEF.md
# Microstep Winding Current Sequencer

This block turns step and direction commands into per-winding current commands for a two-phase bipolar stepper motor. It keeps a position inside a 16-entry electrical cycle and, for each of the two windings, derives a polarity bit and a 2-bit current-level code that selects 0%, 33%, 67% or 100% of the maximum winding current. A downstream chopper stage consumes these codes. The chopper and the analog reference are not part of this block.

A 2-bit mode input selects full, half or quarter stepping, which sets how far each step moves through the cycle. A separate reduce input gives the modified variant, where the diagonal positions that would drive both windings at full current drive 67% instead. An enable input de-energizes both windings and freezes the position. A mode change moves the position down to the nearest point that the new mode can reach.

Top module: `ustep_current_seq`

## Requirements
- R1: Level codes are inverted-sense: 2'b00 means 100%, 2'b01 means 67%, 2'b10 means 33% and 2'b11 means 0%. A phase bit of 1 means positive current and 0 means negative. The phase bit carries no meaning when the level is 0%.
- R2: While reset is low, both level codes are 2'b11. Reset places the position at 2 and the registered mode at full. With enable high, reduce low and mode full, the first cycle after reset shows both windings at 100% with phase 1.
- R3: For position p (0..15), let h = p mod 8. The magnitude of winding 1 is 0% for h=0, 33% for h=1 and h=7, 100% for h=3, 4 and 5, and either 100% or 67% (see R6) for h=2 and h=6. Its phase is 1 for p<8 and 0 for p>=8. Winding 2 uses position (p+4) mod 16. The outputs are registered and reflect a change one clock after the input is sampled.
- R4: Mode 0 is full step (stride 4), mode 1 is half step (stride 2), and modes 2 and 3 are quarter step (stride 1). Each accepted step adds the stride when dir_i is 0 and subtracts it when dir_i is 1, modulo 16.
- R5: A step is accepted on the rising edge of step_i. Holding step_i high advances the position only once.
- R6: When reduce_i is 1, positions with h=2 or h=6 output 67% (2'b01) instead of 100%, so both windings are never at 100% together.
- R7: While en_i is low, both level codes are 2'b11 from the next cycle on. Step edges are ignored, and the position is kept for when en_i returns high.
- R8: When mode_i differs from the registered mode, the position moves to the nearest lower valid position, wrapping below 0. For full step a valid position has p mod 4 = 2. For half step a valid position is even. For quarter step every position is valid. A step edge in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step request, acted on at its rising edge |
| dir_i | input | 1 | 0 steps forward, 1 steps backward |
| mode_i | input | 2 | 0 full, 1 half, 2 and 3 quarter |
| reduce_i | input | 1 | Use 67% at the diagonal positions |
| en_i | input | 1 | Energize the windings and accept steps |
| w1_phase_o | output | 1 | Winding 1 polarity |
| w1_lvl_o | output | 2 | Winding 1 level code |
| w2_phase_o | output | 1 | Winding 2 polarity |
| w2_lvl_o | output | 2 | Winding 2 level code |

## Verification
Stepping is swept over every mode, both reduce settings and both directions for more than one full electrical cycle. The sweep shows that each stride walks the right subset of positions, that the quarter-cycle offset of winding 2 is right, and that the 67% substitution lands only on the diagonals. The mode-change test starts from each of the 16 positions and switches to full and to half. This separates correct downward alignment, including the wrap below zero, from rounding up or leaving the position unchanged. Further tests hold step_i high, disable the block while stepping and combine a step with a mode change. These show that only edges count, that the position survives a disable, and that alignment takes priority over a step.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int POS_W = 4;
    localparam int NPOS  = 1 << POS_W;
    localparam int QTR   = NPOS / 4;

    localparam logic [1:0] MODE_FULL = 2'd0;
    localparam logic [1:0] MODE_HALF = 2'd1;

    localparam logic [1:0] LVL_100 = 2'b00;
    localparam logic [1:0] LVL_67  = 2'b01;
    localparam logic [1:0] LVL_33  = 2'b10;
    localparam logic [1:0] LVL_0   = 2'b11;

    localparam logic [POS_W-1:0] RESET_POS = POS_W'(2);

    typedef struct packed {
        logic       pol;
        logic [1:0] lvl;
    } wind_t;

    function automatic logic [POS_W-1:0] stride_of(logic [1:0] m);
        logic [POS_W-1:0] s;
        case (m)
            MODE_FULL: s = POS_W'(4);
            MODE_HALF: s = POS_W'(2);
            default:   s = POS_W'(1);
        endcase
        return s;
    endfunction

    function automatic logic [POS_W-1:0] align_pos(logic [POS_W-1:0] p, logic [1:0] m);
        logic [POS_W-1:0] r;
        r = p;
        case (m)
            MODE_FULL: begin
                r = {p[POS_W-1:2], 2'b10};
                if (!p[1]) r = r - POS_W'(4);
            end
            MODE_HALF: r = {p[POS_W-1:1], 1'b0};
            default:   r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ustep_index.sv
module ustep_index
    import ustep_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    input  logic             en_i,
    output logic [POS_W-1:0] idx_d_o,
    output logic [POS_W-1:0] idx_q_o,
    output logic [1:0]       mode_q_o,
    output logic             step_q_o
);

    typedef struct packed {
        logic [POS_W-1:0] idx;
        logic [1:0]       mode;
        logic             step_prev;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d           = st_q;
        st_d.step_prev = step_i;
        st_d.mode      = mode_i;
        rise           = step_i & ~st_q.step_prev;
        if (mode_i != st_q.mode) begin
            st_d.idx = align_pos(st_q.idx, mode_i);
        end else if (en_i && rise) begin
            if (dir_i) st_d.idx = st_q.idx - stride_of(mode_i);
            else       st_d.idx = st_q.idx + stride_of(mode_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.idx       <= RESET_POS;
            st_q.mode      <= MODE_FULL;
            st_q.step_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_d_o  = st_d.idx;
    assign idx_q_o  = st_q.idx;
    assign mode_q_o = st_q.mode;
    assign step_q_o = st_q.step_prev;

endmodule

// File: rtl/ustep_level.sv
module ustep_level
    import ustep_pkg::*;
(
    input  logic [POS_W-1:0] pos_i,
    input  logic             reduce_i,
    output logic [1:0]       lvl_o,
    output logic             pol_o
);

    logic [2:0] half_pos;

    always_comb begin
        half_pos = pos_i[2:0];
        case (half_pos)
            3'd0:       lvl_o = LVL_0;
            3'd1, 3'd7: lvl_o = LVL_33;
            3'd2, 3'd6: lvl_o = reduce_i ? LVL_67 : LVL_100;
            default:    lvl_o = LVL_100;
        endcase
        pol_o = ~pos_i[POS_W-1];
    end

endmodule

// File: rtl/ustep_current_seq.sv
module ustep_current_seq
    import ustep_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       step_i,
    input  logic       dir_i,
    input  logic [1:0] mode_i,
    input  logic       reduce_i,
    input  logic       en_i,
    output logic       w1_phase_o,
    output logic [1:0] w1_lvl_o,
    output logic       w2_phase_o,
    output logic [1:0] w2_lvl_o
);

    localparam int NWIND = 2;

    logic [POS_W-1:0] idx_d, idx_q;
    logic [1:0]       mode_q;
    logic             step_q;

    logic [1:0]       raw_lvl [NWIND];
    logic             raw_pol [NWIND];
    wind_t            out_d   [NWIND];
    wind_t            out_q   [NWIND];

    ustep_index u_index (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step_i),
        .dir_i    (dir_i),
        .mode_i   (mode_i),
        .en_i     (en_i),
        .idx_d_o  (idx_d),
        .idx_q_o  (idx_q),
        .mode_q_o (mode_q),
        .step_q_o (step_q)
    );

    for (genvar k = 0; k < NWIND; k++) begin : g_wind
        logic [POS_W-1:0] pos;
        assign pos = idx_d + POS_W'(k * QTR);

        ustep_level u_level (
            .pos_i    (pos),
            .reduce_i (reduce_i),
            .lvl_o    (raw_lvl[k]),
            .pol_o    (raw_pol[k])
        );

        always_comb begin
            out_d[k].lvl = en_i ? raw_lvl[k] : LVL_0;
            out_d[k].pol = en_i ? raw_pol[k] : 1'b0;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                out_q[k].lvl <= LVL_0;
                out_q[k].pol <= 1'b0;
            end else begin
                out_q[k] <= out_d[k];
            end
        end
    end

    assign w1_phase_o = out_q[0].pol;
    assign w1_lvl_o   = out_q[0].lvl;
    assign w2_phase_o = out_q[1].pol;
    assign w2_lvl_o   = out_q[1].lvl;

endmodule

// File: rtl/ustep_current_seq_chk.sv
module ustep_current_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       step_i,
    input logic       dir_i,
    input logic [1:0] mode_i,
    input logic       reduce_i,
    input logic       en_i,
    input logic [1:0] w1_lvl_o,
    input logic [1:0] w2_lvl_o,
    input logic [3:0] idx_q,
    input logic [1:0] mode_q,
    input logic       step_q
);

    p_idle_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i) |-> (w1_lvl_o == 2'b11 && w2_lvl_o == 2'b11));

    p_hold_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i && mode_i == mode_q) |-> $stable(idx_q));

    p_full_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == 2'd0) |-> (idx_q[1:0] == 2'b10));

    p_half_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == 2'd1) |-> (idx_q[0] == 1'b0));

    p_no_twin_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(reduce_i && en_i) |-> !(w1_lvl_o == 2'b00 && w2_lvl_o == 2'b00));

    p_quarter_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i && step_i && !step_q && !dir_i && mode_i == 2'd2 && mode_q == 2'd2)
        |-> (idx_q == $past(idx_q) + 4'd1));

    p_full_rev_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i && step_i && !step_q && dir_i && mode_i == 2'd0 && mode_q == 2'd0)
        |-> (idx_q == $past(idx_q) - 4'd4));

    p_held_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(step_i && step_q && mode_i == mode_q) |-> $stable(idx_q));

endmodule

bind ustep_current_seq ustep_current_seq_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .dir_i    (dir_i),
    .mode_i   (mode_i),
    .reduce_i (reduce_i),
    .en_i     (en_i),
    .w1_lvl_o (w1_lvl_o),
    .w2_lvl_o (w2_lvl_o),
    .idx_q    (idx_q),
    .mode_q   (mode_q),
    .step_q   (step_q)
);

// File: tb/test_ustep_current_seq.sv
module test_ustep_current_seq;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       step_i = 1'b0;
    logic       dir_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       reduce_i = 1'b0;
    logic       en_i = 1'b1;
    logic       w1_phase_o, w2_phase_o;
    logic [1:0] w1_lvl_o, w2_lvl_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_idx;
    int m_mode;

    always #10 clk_i = ~clk_i;

    ustep_current_seq i_ustep_current_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (step_i),
        .dir_i      (dir_i),
        .mode_i     (mode_i),
        .reduce_i   (reduce_i),
        .en_i       (en_i),
        .w1_phase_o (w1_phase_o),
        .w1_lvl_o   (w1_lvl_o),
        .w2_phase_o (w2_phase_o),
        .w2_lvl_o   (w2_lvl_o)
    );

    function automatic int pct_at(int p, bit red);
        int h;
        h = p % 8;
        if (h == 0) return 0;
        if (h == 1 || h == 7) return 33;
        if (h == 2 || h == 6) return red ? 67 : 100;
        return 100;
    endfunction

    function automatic logic [1:0] code_of(int pct);
        if (pct == 100) return 2'b00;
        if (pct == 67)  return 2'b01;
        if (pct == 33)  return 2'b10;
        return 2'b11;
    endfunction

    function automatic int stride(int m);
        if (m == 0) return 4;
        if (m == 1) return 2;
        return 1;
    endfunction

    function automatic int realign(int p, int m);
        int q;
        q = p;
        if (m == 0) while (q % 4 != 2) q = (q + 15) % 16;
        else if (m == 1) while (q % 2 != 0) q = (q + 15) % 16;
        return q;
    endfunction

    task automatic check_one(string req, string wname, int p, logic [1:0] lvl, logic ph);
        logic [1:0] el;
        logic       ep;
        el = en_i ? code_of(pct_at(p, reduce_i)) : 2'b11;
        ep = (p < 8);
        total++;
        if (lvl !== el || (el != 2'b11 && ph !== ep)) begin
            bad++;
            $display("FAIL %s %s pos=%0d: lvl=%b phase=%b expected lvl=%b phase=%b",
                     req, wname, p, lvl, ph, el, ep);
        end
    endtask

    task automatic check_out(string req);
        check_one(req, "w1", m_idx, w1_lvl_o, w1_phase_o);
        check_one(req, "w2", (m_idx + 4) % 16, w2_lvl_o, w2_phase_o);
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        step_i = 1'b0;
        mode_i = 2'd0;
        repeat (2) @(negedge clk_i);
        total++;
        if (w1_lvl_o !== 2'b11 || w2_lvl_o !== 2'b11) begin
            bad++;
            $display("FAIL R2 in reset: lvl=%b/%b expected 11/11", w1_lvl_o, w2_lvl_o);
        end
        rst_ni = 1'b1;
        m_idx = 2;
        m_mode = 0;
        @(negedge clk_i);
    endtask

    task automatic do_step(string req);
        step_i = 1'b1;
        @(negedge clk_i);
        step_i = 1'b0;
        if (en_i) begin
            if (dir_i) m_idx = (m_idx + 16 - stride(m_mode)) % 16;
            else       m_idx = (m_idx + stride(m_mode)) % 16;
        end
        check_out(req);
        @(negedge clk_i);
    endtask

    task automatic set_mode(int m, string req);
        mode_i = m[1:0];
        @(negedge clk_i);
        if (m != m_mode) m_idx = realign(m_idx, m);
        m_mode = m;
        check_out(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        en_i = 1'b1;
        reduce_i = 1'b0;
        do_reset();
        check_out("R2 first cycle after reset");

        // R3 R4 R6 R1: sweep every mode, reduce setting and direction
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int d = 0; d < 2; d++) begin
                    do_reset();
                    reduce_i = r[0];
                    dir_i = d[0];
                    set_mode(m, "R8 from reset position");
                    for (int s = 0; s < 18; s++) do_step("R3 R4 R6 R1 sweep");
                end
            end
        end

        // R8: realign from every position into full and half
        for (int tm = 0; tm < 2; tm++) begin
            for (int start = 0; start < 16; start++) begin
                do_reset();
                reduce_i = 1'b0;
                dir_i = 1'b0;
                set_mode(2, "R8 into quarter");
                while (m_idx != start) do_step("R4 walk");
                set_mode(tm, "R8 realign");
            end
        end

        // R8: step edge in the cycle of a mode change is ignored
        do_reset();
        set_mode(2, "R8 into quarter");
        do_step("R4 quarter step");
        mode_i = 2'd1;
        step_i = 1'b1;
        @(negedge clk_i);
        step_i = 1'b0;
        m_idx = realign(m_idx, 1);
        m_mode = 1;
        check_out("R8 step with mode change");
        @(negedge clk_i);
        check_out("R8 after mode change");

        // R5: held step advances once
        do_reset();
        dir_i = 1'b0;
        step_i = 1'b1;
        @(negedge clk_i);
        m_idx = (m_idx + 4) % 16;
        check_out("R5 first edge");
        repeat (5) @(negedge clk_i);
        check_out("R5 held high");
        step_i = 1'b0;
        @(negedge clk_i);
        check_out("R5 released");

        // R7: disable blanks outputs and freezes position
        do_reset();
        set_mode(2, "R8 into quarter");
        do_step("R4 before disable");
        en_i = 1'b0;
        @(negedge clk_i);
        check_out("R7 disabled");
        for (int s = 0; s < 3; s++) do_step("R7 step while disabled");
        en_i = 1'b1;
        @(negedge clk_i);
        check_out("R7 position kept");
        do_step("R7 stepping resumes");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule